// File: doc/BRIEF.md
# Crystal Oscillator Startup Sequencer

This block brings a crystal oscillator up from cold. It runs entirely on the 32 kHz sleep clock, because the main reference clock does not exist until the oscillator is running. While idle it holds the bias-current DAC at a default code. On a start request it drives the DAC at three times a programmed nominal code so that oscillation is sure to begin. It then drops to the nominal code and finally settles on a corrected code.

A 5-bit amplitude-detector reading is smoothed by a single-pole shift filter and compared against two programmable thresholds. A free-running time base records when the first threshold is crossed and when the second is crossed. The difference between the two times is the measured interval. A serial divider then scales the nominal code by the ratio of the measured interval to an expected interval. The result is clamped to the largest DAC code.

If a threshold is never reached, a per-phase watchdog abandons the sequence and returns the sequencer to idle. It also raises an error flag.

Top module: `xoStartupSeq`

## Requirements
- R1: After reset, and while idle, `phase` is 0, `idacCode` is 128, `done` is 0 and `timeoutErr` is 0.
- R2: A `startReq` seen in idle (phase 0) or settled (phase 4) starts a new sequence. From the next cycle the phase is quick charge (phase 1) and `idacCode` = min(3·`idacNominal`, 255). `timeoutErr` is cleared.
- R3: Each cycle the filter state updates as acc ← acc − (acc >> 2) + `adcSample`, and it is cleared to zero when a sequence starts. The filtered value is acc >> 2. A crossing means filtered ≥ threshold.
- R4: If the first-threshold crossing is detected in quick-charge cycle k (cycle 0 being the first), the ramp phase (phase 2) begins in cycle k+2.
- R5: During the ramp phase `idacCode` equals `idacNominal`. The cycle after the filtered value reaches `thrSecond`, the phase becomes calculation (phase 3). The measured interval is the number of cycles between the first-crossing detection and the second-crossing detection.
- R6: The calculation phase lasts exactly 20 cycles, with `idacCode` = `idacNominal`, and is then followed by the settled phase.
- R7: In the settled phase `done` is 1 and `idacCode` = min(floor(nominal·interval / `expectedTime`), 255). The nominal and expected values are taken when calculation begins. An expected time of 0 yields 255.
- R8: If quick charge or ramp runs for 600 cycles without its crossing, the sequencer returns to idle with `timeoutErr` = 1. The flag holds until the next start.
- R9: `startReq` has no effect during quick charge, ramp or calculation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32 kHz sleep clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Begin a startup sequence |
| adcSample | input | 5 | Amplitude-detector ADC reading |
| thrFirst | input | 5 | Threshold that ends quick charge |
| thrSecond | input | 5 | Threshold that ends the ramp |
| idacNominal | input | 8 | Nominal bias DAC code |
| expectedTime | input | 12 | Expected crossing interval in cycles |
| idacCode | output | 8 | Bias-current DAC codeword |
| phase | output | 3 | 0 idle, 1 quick charge, 2 ramp, 3 calculation, 4 settled |
| done | output | 1 | Sequence finished, final code applied |
| timeoutErr | output | 1 | A phase timed out |

## Verification
The hardest case to reach is a watchdog expiry in the ramp phase. The filtered amplitude must first climb past the first threshold, and only then stall below the second. The stimulus does this by watching the phase output and switching the ADC reading from a high value to a low one once the ramp begins. A second hard case is a start request that arrives inside the short calculation window. This is done by pulsing the request a few cycles after phase 3 is observed and checking that the window still lasts its full length. A behavioural model compares every output on every cycle, so the exact cycle of each transition is checked as well as the final ratio.

// File: rtl/xo_startup_pkg.sv
package xo_startup_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_CHARGE  = 3'd1,
    PH_RAMP    = 3'd2,
    PH_CALC    = 3'd3,
    PH_SETTLED = 3'd4
  } phase_e;

  typedef struct packed {
    logic clearAll;
    logic captureT1;
    logic loadDiv;
    logic stepDiv;
  } dp_strobe_t;

endpackage

// File: rtl/xoStartupDatapath.sv
module xoStartupDatapath
  import xo_startup_pkg::*;
#(
  parameter int ADC_W      = 5,
  parameter int IDAC_W     = 8,
  parameter int TIME_W     = 12,
  parameter int FILT_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dp_strobe_t        strobe,
  input  logic [ADC_W-1:0]  adcSample,
  input  logic [ADC_W-1:0]  thrFirst,
  input  logic [ADC_W-1:0]  thrSecond,
  input  logic [IDAC_W-1:0] idacNominal,
  input  logic [TIME_W-1:0] expectedTime,
  output logic              hitFirst,
  output logic              hitSecond,
  output logic [IDAC_W-1:0] finalCode
);
  localparam int ACC_W = ADC_W + FILT_SHIFT;
  localparam int NUM_W = IDAC_W + TIME_W;

  logic [ACC_W-1:0]  acc, accNext;
  logic [ADC_W-1:0]  filtered;
  logic [TIME_W-1:0] timeNow, timeFirst, divisor, rem;
  logic [NUM_W-1:0]  quo;
  logic [TIME_W:0]   remShift;
  logic              fits;

  // single-pole smoothing: acc tracks adc scaled by 2^FILT_SHIFT
  assign accNext  = acc - (acc >> FILT_SHIFT) + ACC_W'(adcSample);
  assign filtered = acc[ACC_W-1:FILT_SHIFT];
  assign hitFirst  = (filtered >= thrFirst);
  assign hitSecond = (filtered >= thrSecond);

  // restoring divider, one quotient bit per sleep-clock cycle
  assign remShift = {rem, quo[NUM_W-1]};
  assign fits     = (remShift >= {1'b0, divisor});
  assign finalCode = (|quo[NUM_W-1:IDAC_W]) ? '1 : quo[IDAC_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      timeNow   <= '0;
      timeFirst <= '0;
      divisor   <= '0;
      rem       <= '0;
      quo       <= '0;
    end else begin
      acc <= strobe.clearAll ? '0 : accNext;
      if (strobe.clearAll)    timeNow <= '0;
      else if (timeNow != '1) timeNow <= timeNow + 1'b1;
      if (strobe.captureT1) timeFirst <= timeNow;
      if (strobe.loadDiv) begin
        quo     <= NUM_W'(idacNominal) * NUM_W'(timeNow - timeFirst);
        rem     <= '0;
        divisor <= expectedTime;
      end else if (strobe.stepDiv) begin
        quo <= {quo[NUM_W-2:0], fits};
        rem <= fits ? TIME_W'(remShift - {1'b0, divisor}) : remShift[TIME_W-1:0];
      end
    end
  end

  // time base never runs backwards between starts
  assert_time_monotonic_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.clearAll |=> (timeNow >= $past(timeNow)));

  // partial remainder stays below a nonzero divisor
  assert_rem_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor != '0) |-> (rem < divisor));

endmodule

// File: rtl/xoStartupControl.sv
module xoStartupControl
  import xo_startup_pkg::*;
#(
  parameter int IDAC_W       = 8,
  parameter int TIMEOUT_CYC  = 600,
  parameter int DIV_STEPS    = 20,
  parameter int DEFAULT_CODE = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              startReq,
  input  logic              hitFirst,
  input  logic              hitSecond,
  input  logic [IDAC_W-1:0] finalCode,
  input  logic [IDAC_W-1:0] idacNominal,
  output dp_strobe_t        strobe,
  output logic [2:0]        phase,
  output logic [IDAC_W-1:0] idacCode,
  output logic              done,
  output logic              timeoutErr
);
  localparam int CNT_W  = $clog2(TIMEOUT_CYC);
  localparam int STEP_W = $clog2(DIV_STEPS);

  phase_e            state, stateNext;
  logic              armed, timeoutHit;
  logic [CNT_W-1:0]  phaseCnt;
  logic [STEP_W-1:0] divCnt;
  logic [IDAC_W+1:0] triple;
  logic              cntLast;

  assign triple  = {1'b0, idacNominal, 1'b0} + {2'b00, idacNominal};
  assign cntLast = (phaseCnt == CNT_W'(TIMEOUT_CYC - 1));

  always_comb begin
    stateNext  = state;
    strobe     = '0;
    timeoutHit = 1'b0;
    case (state)
      PH_IDLE, PH_SETTLED:
        if (startReq) begin
          stateNext       = PH_CHARGE;
          strobe.clearAll = 1'b1;
        end
      PH_CHARGE:
        if (armed) stateNext = PH_RAMP;
        else if (hitFirst) strobe.captureT1 = 1'b1;
        else if (cntLast) begin
          stateNext  = PH_IDLE;
          timeoutHit = 1'b1;
        end
      PH_RAMP:
        if (hitSecond) begin
          stateNext      = PH_CALC;
          strobe.loadDiv = 1'b1;
        end else if (cntLast) begin
          stateNext  = PH_IDLE;
          timeoutHit = 1'b1;
        end
      PH_CALC: begin
        strobe.stepDiv = 1'b1;
        if (divCnt == STEP_W'(DIV_STEPS - 1)) stateNext = PH_SETTLED;
      end
      default: stateNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= PH_IDLE;
      armed      <= 1'b0;
      phaseCnt   <= '0;
      divCnt     <= '0;
      timeoutErr <= 1'b0;
    end else begin
      state <= stateNext;
      if (strobe.clearAll)       armed <= 1'b0;
      else if (strobe.captureT1) armed <= 1'b1;
      if (stateNext != state) phaseCnt <= '0;
      else if (state == PH_CHARGE || state == PH_RAMP) phaseCnt <= phaseCnt + 1'b1;
      if (strobe.loadDiv)        divCnt <= '0;
      else if (state == PH_CALC) divCnt <= divCnt + 1'b1;
      if (strobe.clearAll)  timeoutErr <= 1'b0;
      else if (timeoutHit)  timeoutErr <= 1'b1;
    end
  end

  always_comb begin
    case (state)
      PH_CHARGE:        idacCode = (|triple[IDAC_W+1:IDAC_W]) ? '1 : triple[IDAC_W-1:0];
      PH_RAMP, PH_CALC: idacCode = idacNominal;
      PH_SETTLED:       idacCode = finalCode;
      default:          idacCode = IDAC_W'(DEFAULT_CODE);
    endcase
  end

  assign phase = state;
  assign done  = (state == PH_SETTLED);

  // ramp begins two cycles after the first crossing was seen
  assert_ramp_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == PH_RAMP) |-> $past(hitFirst, 2));

  // completion only follows the calculation window
  assert_settle_after_calc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(state == PH_CALC));

  // the error flag only rises out of a watched phase
  assert_err_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeoutErr) |-> $past(state == PH_CHARGE || state == PH_RAMP));

  // a request mid-sequence does not restart it
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == PH_RAMP || state == PH_CALC) && startReq) |=> (state != PH_CHARGE));

endmodule

// File: rtl/xoStartupSeq.sv
module xoStartupSeq
  import xo_startup_pkg::*;
#(
  parameter int ADC_W        = 5,
  parameter int IDAC_W       = 8,
  parameter int TIME_W       = 12,
  parameter int FILT_SHIFT   = 2,
  parameter int TIMEOUT_CYC  = 600,
  parameter int DEFAULT_CODE = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              startReq,
  input  logic [ADC_W-1:0]  adcSample,
  input  logic [ADC_W-1:0]  thrFirst,
  input  logic [ADC_W-1:0]  thrSecond,
  input  logic [IDAC_W-1:0] idacNominal,
  input  logic [TIME_W-1:0] expectedTime,
  output logic [IDAC_W-1:0] idacCode,
  output logic [2:0]        phase,
  output logic              done,
  output logic              timeoutErr
);
  localparam int DIV_STEPS = IDAC_W + TIME_W;

  dp_strobe_t        strobe;
  logic              hitFirst, hitSecond;
  logic [IDAC_W-1:0] finalCode;

  xoStartupDatapath #(
    .ADC_W(ADC_W), .IDAC_W(IDAC_W), .TIME_W(TIME_W), .FILT_SHIFT(FILT_SHIFT)
  ) uData (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .adcSample(adcSample), .thrFirst(thrFirst), .thrSecond(thrSecond),
    .idacNominal(idacNominal), .expectedTime(expectedTime),
    .hitFirst(hitFirst), .hitSecond(hitSecond), .finalCode(finalCode)
  );

  xoStartupControl #(
    .IDAC_W(IDAC_W), .TIMEOUT_CYC(TIMEOUT_CYC),
    .DIV_STEPS(DIV_STEPS), .DEFAULT_CODE(DEFAULT_CODE)
  ) uCtrl (
    .clk(clk), .rst_n(rst_n), .startReq(startReq),
    .hitFirst(hitFirst), .hitSecond(hitSecond),
    .finalCode(finalCode), .idacNominal(idacNominal),
    .strobe(strobe), .phase(phase), .idacCode(idacCode),
    .done(done), .timeoutErr(timeoutErr)
  );

endmodule

// File: tb/sim_xoStartupSeq.sv
module sim_xoStartupSeq;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 600;
  localparam int STEPS      = 20;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        startReq = 0;
  logic [4:0]  adcSample = 0, thrFirst = 0, thrSecond = 0;
  logic [7:0]  idacNominal = 0;
  logic [11:0] expectedTime = 0;
  logic [7:0]  idacCode;
  logic [2:0]  phase;
  logic        done, timeoutErr;

  int total = 0, bad = 0, cycles = 0;
  bit live = 0;

  int mState = 0, mAcc = 0, mTimer = 0, mT1 = 0, mArmed = 0, mPc = 0, mDc = 0;
  int mErr = 0, mNomL = 0, mExpL = 0, mFinal = 0, mFilt = 0, mOldT = 0, mMeas = 0;

  xoStartupSeq u0 (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .adcSample(adcSample),
    .thrFirst(thrFirst), .thrSecond(thrSecond), .idacNominal(idacNominal),
    .expectedTime(expectedTime), .idacCode(idacCode), .phase(phase),
    .done(done), .timeoutErr(timeoutErr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic string tagOf(input int st);
    case (st)
      0: return "R1";
      1: return "R2";
      2: return "R5";
      3: return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic int modelIdac();
    case (mState)
      0: return 128;
      1: return (3 * idacNominal > 255) ? 255 : 3 * idacNominal;
      2, 3: return idacNominal;
      default: return mFinal;
    endcase
  endfunction

  // behavioural reference, stepped on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      mState = 0; mAcc = 0; mTimer = 0; mT1 = 0; mArmed = 0; mPc = 0; mDc = 0; mErr = 0;
    end else begin
      mFilt = mAcc >> 2;
      mOldT = mTimer;
      if ((mState == 0 || mState == 4) && startReq) begin
        mState = 1; mArmed = 0; mPc = 0; mErr = 0; mAcc = 0; mTimer = 0;
      end else begin
        case (mState)
          1: if (mArmed) begin mState = 2; mPc = 0; end
             else if (mFilt >= thrFirst) begin mArmed = 1; mT1 = mOldT; mPc++; end
             else if (mPc == LIMIT - 1) begin mState = 0; mErr = 1; end
             else mPc++;
          2: if (mFilt >= thrSecond) begin
               mState = 3; mDc = 0; mMeas = mOldT - mT1;
               mNomL = idacNominal; mExpL = expectedTime;
             end else if (mPc == LIMIT - 1) begin mState = 0; mErr = 1; end
             else mPc++;
          3: if (mDc == STEPS - 1) begin
               mState = 4;
               if (mExpL == 0) mFinal = 255;
               else mFinal = (mNomL * mMeas / mExpL > 255) ? 255 : mNomL * mMeas / mExpL;
             end else mDc++;
          default: ;
        endcase
        mAcc = mAcc - (mAcc >> 2) + adcSample;
        if (mTimer < 4095) mTimer++;
      end
    end
    #3;
    if (live) begin
      check(idacCode == modelIdac(), tagOf(mState), idacCode, modelIdac());
      check(phase == mState, tagOf(mState), phase, mState);
      check(done == (mState == 4), "R7", done, mState == 4);
      check(timeoutErr == mErr, "R8", timeoutErr, mErr);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic runSeq(input int nom, input int expT, input int thA, input int thB,
                        input int lo, input int hi, input bit pokeCalc,
                        output int chargeN, output int rampN, output int calcN,
                        output int endPhase, output int firstIdac, output int rampIdac);
    chargeN = 0; rampN = 0; calcN = 0; firstIdac = -1; rampIdac = -1; endPhase = 0;
    @(negedge clk);
    idacNominal = 8'(nom); expectedTime = 12'(expT);
    thrFirst = 5'(thA); thrSecond = 5'(thB); adcSample = 5'(lo);
    startReq = 1;
    @(negedge clk);
    startReq = 0;
    for (int c = 0; c < 2000; c++) begin
      endPhase = phase;
      if (phase == 1) begin if (chargeN == 0) firstIdac = idacCode; chargeN++; end
      if (phase == 2) begin if (rampN == 0) rampIdac = idacCode; rampN++; end
      if (phase == 3) calcN++;
      if (phase == 0 || phase == 4) break;
      adcSample = (phase >= 2) ? 5'(hi) : 5'(lo);
      startReq = (pokeCalc && (phase == 3) && (calcN == 3));
      @(negedge clk);
    end
    startReq = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int cn, rn, kn, ep, fi, ri;
    repeat (3) @(negedge clk);
    rst_n = 1;
    live = 1;
    @(negedge clk);
    check(phase == 0 && idacCode == 128 && !done && !timeoutErr, "R1", idacCode, 128);

    // normal run
    runSeq(40, 30, 10, 20, 12, 31, 0, cn, rn, kn, ep, fi, ri);
    check(fi == 120, "R2", fi, 120);
    check(ri == 40, "R5", ri, 40);
    check(kn == STEPS, "R6", kn, STEPS);
    check(ep == 4 && done, "R7", ep, 4);

    // restart from settled, request poked inside the calculation window
    runSeq(40, 30, 10, 20, 12, 31, 1, cn, rn, kn, ep, fi, ri);
    check(fi == 120, "R2", fi, 120);
    check(kn == STEPS, "R9", kn, STEPS);
    check(ep == 4, "R9", ep, 4);

    // filter settling fixes the first-crossing cycle
    runSeq(40, 30, 8, 20, 8, 31, 0, cn, rn, kn, ep, fi, ri);
    check(cn == 12, "R3", cn, 12);
    check(cn == 12, "R4", cn, 12);

    // large ratio saturates; triple nominal saturates
    runSeq(200, 1, 5, 20, 31, 31, 0, cn, rn, kn, ep, fi, ri);
    check(fi == 255, "R2", fi, 255);
    check(idacCode == 255, "R7", idacCode, 255);

    // expected time zero
    runSeq(10, 0, 5, 20, 31, 31, 0, cn, rn, kn, ep, fi, ri);
    check(idacCode == 255, "R7", idacCode, 255);

    // timeout in quick charge
    runSeq(40, 30, 5, 20, 0, 0, 0, cn, rn, kn, ep, fi, ri);
    check(cn == LIMIT, "R8", cn, LIMIT);
    check(phase == 0 && timeoutErr && idacCode == 128, "R8", timeoutErr, 1);

    // timeout in ramp
    runSeq(40, 30, 5, 20, 31, 3, 0, cn, rn, kn, ep, fi, ri);
    check(rn == LIMIT, "R8", rn, LIMIT);
    check(timeoutErr == 1, "R8", timeoutErr, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule